// File: doc/BRIEF.md
# Speculative Store Queue

This block sits between the address-generation stage and the cache/memory port of an out-of-order core. Stores arrive in program order with their address and data already computed and are parked in a small circular queue. A parked store may be speculative: it sits behind a predicted branch identified by a tag. It is sent to memory only when two conditions hold. The branch tagged on it must have resolved as correctly predicted, and the completion logic must have confirmed that the store will retire.

Completion confirmations arrive one per cycle and apply in program order to the oldest unconfirmed store. A mispredicted branch removes every unconfirmed store from the first one tagged with that branch onward. A flush removes every unconfirmed store. Confirmed stores drain to memory strictly oldest first through a valid/ready handshake, at up to one per cycle. Enqueue is refused with a full indication when every slot is occupied.

Top module: `spec_store_queue`

## Requirements
- R1: After reset the queue is empty: `enq_full` is 0 and `mem_req_valid` is 0.
- R2: Stores leave on the memory port in the order they were accepted, with address and data exactly as enqueued, and nothing is requested while the queue is empty.
- R3: A store is never requested before a `cmt_valid` pulse has confirmed it. Each accepted pulse confirms the single oldest unconfirmed store.
- R4: A store enqueued with `enq_spec`=1 and tag T is held until `br_valid`=1 with `br_mispredict`=0 and `br_tag`=T. A resolution with any other tag leaves it held. A store enqueued in the same cycle as the matching resolution is stored as non-speculative.
- R5: `br_valid`=1 with `br_mispredict`=1 and `br_tag`=T removes the oldest unconfirmed entry that is still speculative with tag T, together with every younger entry. In that cycle any enqueue and any confirmation are ignored. Confirmed entries are never removed.
- R6: `flush`=1 removes every unconfirmed entry and keeps every confirmed one. In that cycle any enqueue and any confirmation are ignored.
- R7: `enq_full` is 1 exactly when DEPTH entries are held. An enqueue offered while `enq_full` is 1 is dropped, even if a store leaves in the same cycle.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid on the next cycle with the same address and data.
- R9: A non-speculative store enqueued in cycle 0 and confirmed in cycle 1 is requested in cycle 2. With enqueue, confirmation and memory accept each active every cycle, one store drains per cycle.
- R10: A `cmt_valid` pulse while no held entry is unconfirmed has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Offer a store for enqueue |
| enq_addr | input | ADDR_W | Store address |
| enq_data | input | DATA_W | Store data |
| enq_spec | input | 1 | Store sits behind an unresolved branch |
| enq_tag | input | TAG_W | Tag of the branch the store depends on |
| enq_full | output | 1 | No free slot; offers are dropped |
| br_valid | input | 1 | A branch resolves this cycle |
| br_mispredict | input | 1 | The resolving branch was mispredicted |
| br_tag | input | TAG_W | Tag of the resolving branch |
| cmt_valid | input | 1 | Completion confirms the oldest unconfirmed store |
| flush | input | 1 | Discard all unconfirmed stores |
| mem_req_valid | output | 1 | Head store is offered to memory |
| mem_req_ready | input | 1 | Memory accepts the offered store |
| mem_req_addr | output | ADDR_W | Address of the offered store |
| mem_req_data | output | DATA_W | Data of the offered store |

## Verification
A corrupt head pointer or entry count shows at once, on the next cycle's request, as a wrong address or data, a request from an empty queue, or a full flag at the wrong occupancy. A wrong confirmation count or spec bit shows as a request that comes one or more cycles early or never comes. A wrong squash boundary stays hidden until the survivors drain, and then shows as an extra or missing request. The bench therefore compares the full port state every cycle against an arithmetic queue model, so a divergence is caught in the cycle it first reaches the pins.

// File: rtl/stq_pkg.sv
package stq_pkg;

   // Source of the post-cycle occupancy before dequeue and enqueue adjust it.
   typedef enum logic [1:0] {
      LEN_KEEP   = 2'd0,   // no removal this cycle
      LEN_CONFIRMED = 2'd1, // flush: keep confirmed prefix only
      LEN_CUT    = 2'd2    // misprediction: cut at the first match
   } len_src_e;

endpackage

// File: rtl/stq_entry_array.sv
module stq_entry_array #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 3,
   parameter int PTR_W  = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [PTR_W-1:0]             wr_idx,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         wr_spec,
   input  logic [TAG_W-1:0]             wr_tag,
   input  logic                         clr_en,
   input  logic [TAG_W-1:0]             clr_tag,
   input  logic [PTR_W-1:0]             rd_idx,
   output logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data,
   output logic                         rd_spec,
   output logic [DEPTH-1:0]             spec_vec,
   output logic [DEPTH-1:0][TAG_W-1:0]  tag_vec
);

   logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
   logic [DEPTH-1:0][DATA_W-1:0] data_q;

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic hit_wr;
      logic hit_clr;

      assign hit_wr  = wr_en && (wr_idx == PTR_W'(s));
      assign hit_clr = clr_en && (tag_vec[s] == clr_tag);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q[s]   <= '0;
            data_q[s]   <= '0;
            spec_vec[s] <= 1'b0;
            tag_vec[s]  <= '0;
         end else if (hit_wr) begin
            addr_q[s]   <= wr_addr;
            data_q[s]   <= wr_data;
            spec_vec[s] <= wr_spec;
            tag_vec[s]  <= wr_tag;
         end else if (hit_clr) begin
            spec_vec[s] <= 1'b0;
         end
      end
   end

   assign rd_addr = addr_q[rd_idx];
   assign rd_data = data_q[rd_idx];
   assign rd_spec = spec_vec[rd_idx];

endmodule

// File: rtl/stq_squash_find.sv
module stq_squash_find #(
   parameter int DEPTH = 8,
   parameter int TAG_W = 3,
   parameter int PTR_W = 3,
   parameter int CNT_W = 4
) (
   input  logic [PTR_W-1:0]             head,
   input  logic [CNT_W-1:0]             cnt,
   input  logic [CNT_W-1:0]             ccnt,
   input  logic [DEPTH-1:0]             spec_vec,
   input  logic [DEPTH-1:0][TAG_W-1:0]  tag_vec,
   input  logic [TAG_W-1:0]             br_tag,
   output logic                         hit,
   output logic [CNT_W-1:0]             cut_age
);

   // Youngest-to-oldest walk so the last assignment is the oldest match.
   always_comb begin
      logic [PTR_W-1:0] idx;
      hit     = 1'b0;
      cut_age = '0;
      idx     = '0;
      for (int a = DEPTH - 1; a >= 0; a--) begin
         idx = head + PTR_W'(a);
         if ((CNT_W'(a) >= ccnt) && (CNT_W'(a) < cnt) &&
             spec_vec[idx] && (tag_vec[idx] == br_tag)) begin
            hit     = 1'b1;
            cut_age = CNT_W'(a);
         end
      end
   end

endmodule

// File: rtl/stq_ptr_ctrl.sv
module stq_ptr_ctrl
   import stq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int PTR_W = 3,
   parameter int CNT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_req,
   input  logic              deq_fire,
   input  logic              cmt_req,
   input  logic              flush,
   input  logic              mispredict,
   input  logic              cut_hit,
   input  logic [CNT_W-1:0]  cut_age,
   output logic [PTR_W-1:0]  head,
   output logic [PTR_W-1:0]  tail,
   output logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  ccnt,
   output logic              full,
   output logic              enq_fire
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic             squash_cyc;
   logic             cmt_fire;
   len_src_e         len_src;
   logic [CNT_W-1:0] base_len;
   logic [CNT_W-1:0] cnt_n;
   logic [CNT_W-1:0] ccnt_n;

   assign squash_cyc = flush | mispredict;
   assign full       = (cnt == DEPTH_C);
   assign enq_fire   = enq_req & ~full & ~squash_cyc;
   assign cmt_fire   = cmt_req & ~squash_cyc & (ccnt < cnt);
   assign tail       = head + cnt[PTR_W-1:0];

   always_comb begin
      if (flush)                    len_src = LEN_CONFIRMED;
      else if (mispredict && cut_hit) len_src = LEN_CUT;
      else                          len_src = LEN_KEEP;
      unique case (len_src)
         LEN_CONFIRMED: base_len = ccnt;
         LEN_CUT:       base_len = cut_age;
         default:       base_len = cnt;
      endcase
   end

   assign cnt_n  = base_len - CNT_W'(deq_fire) + CNT_W'(enq_fire);
   assign ccnt_n = ccnt - CNT_W'(deq_fire) + CNT_W'(cmt_fire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         cnt  <= '0;
         ccnt <= '0;
      end else begin
         head <= head + PTR_W'(deq_fire);
         cnt  <= cnt_n;
         ccnt <= ccnt_n;
      end
   end

endmodule

// File: rtl/spec_store_queue.sv
module spec_store_queue #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   input  logic [ADDR_W-1:0] enq_addr,
   input  logic [DATA_W-1:0] enq_data,
   input  logic              enq_spec,
   input  logic [TAG_W-1:0]  enq_tag,
   output logic              enq_full,
   input  logic              br_valid,
   input  logic              br_mispredict,
   input  logic [TAG_W-1:0]  br_tag,
   input  logic              cmt_valid,
   input  logic              flush,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_data
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spec_store_queue: DEPTH must be a power of two, at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("spec_store_queue: ADDR_W and DATA_W must be positive");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("spec_store_queue: TAG_W must be positive");
   end

   logic [PTR_W-1:0]            head;
   logic [PTR_W-1:0]            tail;
   logic [CNT_W-1:0]            cnt;
   logic [CNT_W-1:0]            ccnt;
   logic                        full;
   logic                        enq_fire;
   logic                        deq_fire;
   logic                        resolve_ok;
   logic                        mispredict;
   logic                        cut_hit;
   logic [CNT_W-1:0]            cut_age;
   logic                        wr_spec;
   logic                        head_spec;
   logic [DEPTH-1:0]            spec_vec;
   logic [DEPTH-1:0][TAG_W-1:0] tag_vec;

   assign resolve_ok = br_valid & ~br_mispredict;
   assign mispredict = br_valid &  br_mispredict;
   assign wr_spec    = enq_spec & ~(resolve_ok && (enq_tag == br_tag));

   stq_ptr_ctrl #(
      .DEPTH (DEPTH),
      .PTR_W (PTR_W),
      .CNT_W (CNT_W)
   ) ptr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .enq_req    (enq_valid),
      .deq_fire   (deq_fire),
      .cmt_req    (cmt_valid),
      .flush      (flush),
      .mispredict (mispredict),
      .cut_hit    (cut_hit),
      .cut_age    (cut_age),
      .head       (head),
      .tail       (tail),
      .cnt        (cnt),
      .ccnt       (ccnt),
      .full       (full),
      .enq_fire   (enq_fire)
   );

   stq_entry_array #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W),
      .PTR_W  (PTR_W)
   ) arr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (enq_fire),
      .wr_idx   (tail),
      .wr_addr  (enq_addr),
      .wr_data  (enq_data),
      .wr_spec  (wr_spec),
      .wr_tag   (enq_tag),
      .clr_en   (resolve_ok),
      .clr_tag  (br_tag),
      .rd_idx   (head),
      .rd_addr  (mem_req_addr),
      .rd_data  (mem_req_data),
      .rd_spec  (head_spec),
      .spec_vec (spec_vec),
      .tag_vec  (tag_vec)
   );

   stq_squash_find #(
      .DEPTH (DEPTH),
      .TAG_W (TAG_W),
      .PTR_W (PTR_W),
      .CNT_W (CNT_W)
   ) find_i (
      .head     (head),
      .cnt      (cnt),
      .ccnt     (ccnt),
      .spec_vec (spec_vec),
      .tag_vec  (tag_vec),
      .br_tag   (br_tag),
      .hit      (cut_hit),
      .cut_age  (cut_age)
   );

   // Head is confirmed whenever any confirmed entry exists (confirmation is in order).
   assign mem_req_valid = (ccnt != '0) & ~head_spec;
   assign deq_fire      = mem_req_valid & mem_req_ready;
   assign enq_full      = full;

endmodule

// File: rtl/stq_checker.sv
module stq_checker #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  ccnt,
   input logic              enq_full,
   input logic              flush,
   input logic              br_valid,
   input logic              br_mispredict,
   input logic              cmt_valid,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [DATA_W-1:0] mem_req_data
);

   AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> !mem_req_valid); // R2

   AST_CONFIRM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ccnt <= cnt); // R3

   AST_CUT_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_mispredict && !flush) |=> (cnt <= $past(cnt))); // R5

   AST_FLUSH_KEEPS_CONFIRMED: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt == ccnt)); // R6

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_full && !(mem_req_valid && mem_req_ready) && !flush &&
       !(br_valid && br_mispredict)) |=> enq_full); // R7

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data))); // R8

   AST_IDLE_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_valid && (ccnt == cnt)) |=> (ccnt <= $past(ccnt))); // R10

endmodule

bind spec_store_queue stq_checker #(
   .DEPTH  (DEPTH),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .cnt           (cnt),
   .ccnt          (ccnt),
   .enq_full      (enq_full),
   .flush         (flush),
   .br_valid      (br_valid),
   .br_mispredict (br_mispredict),
   .cmt_valid     (cmt_valid),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .mem_req_data  (mem_req_data)
);

// File: tb/spec_store_queue_tb_top.sv
`timescale 1ns/1ps
module spec_store_queue_tb_top;

   localparam int D  = 4;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int TW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enq_valid = 0, enq_spec = 0, br_valid = 0, br_mispredict = 0;
   logic cmt_valid = 0, flush = 0, mem_req_ready = 0;
   logic [AW-1:0] enq_addr = '0;
   logic [DW-1:0] enq_data = '0;
   logic [TW-1:0] enq_tag = '0, br_tag = '0;
   logic enq_full, mem_req_valid;
   logic [AW-1:0] mem_req_addr;
   logic [DW-1:0] mem_req_data;

   always #4 clk = ~clk;

   spec_store_queue #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_data(enq_data),
      .enq_spec(enq_spec), .enq_tag(enq_tag), .enq_full(enq_full),
      .br_valid(br_valid), .br_mispredict(br_mispredict), .br_tag(br_tag),
      .cmt_valid(cmt_valid), .flush(flush),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [AW-1:0] qa[$];
   logic [DW-1:0] qd[$];
   logic          qs[$];
   logic [TW-1:0] qt[$];
   int            mc = 0;
   logic [15:0]   seq = 16'h1000;

   function automatic void chk(string req, logic ok, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endfunction

   function automatic logic model_valid();
      return (qa.size() > 0) && (mc > 0) && !qs[0];
   endfunction

   function automatic void check_ports();
      logic ev;
      ev = model_valid();
      chk("R3/R4/R5/R6 request valid", mem_req_valid == ev, 32'(mem_req_valid), 32'(ev));
      if (ev) begin
         chk("R2 request address", mem_req_addr == qa[0], 32'(mem_req_addr), 32'(qa[0]));
         chk("R2 request data", mem_req_data == qd[0], 32'(mem_req_data), 32'(qd[0]));
      end
      chk("R7 full flag", enq_full == (qa.size() == D), 32'(enq_full), 32'(qa.size() == D));
   endfunction

   // Called at a falling edge: check, drive, advance model, wait one cycle.
   task automatic cyc(input logic ev, input logic es, input logic [TW-1:0] et,
                      input logic cv, input logic bv, input logic bm,
                      input logic [TW-1:0] bt, input logic fl, input logic rdy);
      int sz, mc0, cut;
      logic sq, deq;
      logic [AW-1:0] na;
      logic [DW-1:0] nd;
      check_ports();
      seq = seq + 16'h0101;
      na = seq;
      nd = ~seq ^ 16'h5a5a;
      enq_valid = ev; enq_addr = na; enq_data = nd; enq_spec = es; enq_tag = et;
      cmt_valid = cv; br_valid = bv; br_mispredict = bm; br_tag = bt;
      flush = fl; mem_req_ready = rdy;
      sz  = qa.size();
      mc0 = mc;
      sq  = fl | (bv & bm);
      deq = model_valid() & rdy;
      if (deq) begin
         void'(qa.pop_front()); void'(qd.pop_front());
         void'(qs.pop_front()); void'(qt.pop_front());
         mc--;
      end
      if (bv && !bm)
         for (int i = 0; i < qs.size(); i++) if (qt[i] == bt) qs[i] = 1'b0;
      cut = -1;
      if (fl) cut = mc;
      else if (bv && bm)
         for (int j = mc; j < qa.size(); j++)
            if (cut < 0 && qs[j] && qt[j] == bt) cut = j;
      if (cut >= 0)
         while (qa.size() > cut) begin
            void'(qa.pop_back()); void'(qd.pop_back());
            void'(qs.pop_back()); void'(qt.pop_back());
         end
      if (!sq && cv && mc0 < sz) mc++;
      if (!sq && ev && sz < D) begin
         qa.push_back(na); qd.push_back(nd);
         qs.push_back(es && !(bv && !bm && et == bt)); qt.push_back(et);
      end
      @(negedge clk);
   endtask

   task automatic idle(input logic rdy);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, rdy);
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 valid after reset", mem_req_valid == 1'b0, 32'(mem_req_valid), 0);
      chk("R1 full after reset", enq_full == 1'b0, 32'(enq_full), 0);

      // R9: enqueue cycle 0, confirm cycle 1, request cycle 2
      cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R9 no request in cycle 1", mem_req_valid == 1'b0, 32'(mem_req_valid), 0);
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
      chk("R9 request in cycle 2", mem_req_valid == 1'b1, 32'(mem_req_valid), 1);
      idle(1);
      // R9: sustained one per cycle
      cyc(1, 0, 0, 0, 0, 0, 0, 0, 1);
      for (int k = 0; k < 12; k++) begin
         cyc(1, 0, 0, 1, 0, 0, 0, 0, 1);
         if (k > 0) chk("R9 stream request", mem_req_valid == 1'b1, 32'(mem_req_valid), 1);
      end
      repeat (4) cyc(0, 0, 0, 1, 0, 0, 0, 0, 1);
      chk("R2 drained empty", mem_req_valid == 1'b0, 32'(mem_req_valid), 0);

      // R7: fill, offer one more, then drain
      repeat (D) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R7 full at depth", enq_full == 1'b1, 32'(enq_full), 1);
      repeat (D) cyc(1, 0, 0, 1, 0, 0, 0, 0, 0);
      repeat (D) idle(1);
      chk("R7 overflow offer dropped", mem_req_valid == 1'b0, 32'(mem_req_valid), 0);

      // R4: speculative tag 1 held through resolution of tag 2
      cyc(1, 1, 1, 0, 0, 0, 0, 0, 0);
      cyc(1, 1, 1, 1, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
      chk("R4 held while unresolved", mem_req_valid == 1'b0, 32'(mem_req_valid), 0);
      cyc(0, 0, 0, 0, 1, 0, 2, 0, 1);
      chk("R4 held after other tag", mem_req_valid == 1'b0, 32'(mem_req_valid), 0);
      cyc(0, 0, 0, 0, 1, 0, 1, 0, 1);
      chk("R4 released by own tag", mem_req_valid == 1'b1, 32'(mem_req_valid), 1);
      repeat (3) idle(1);

      // R5 / R10: cut at first tag-2 entry, then extra confirm ignored
      cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc(1, 1, 2, 1, 0, 0, 0, 0, 0);
      cyc(1, 1, 3, 0, 0, 0, 0, 0, 0);
      cyc(1, 1, 2, 0, 0, 0, 0, 0, 0);
      cyc(1, 0, 0, 1, 1, 1, 2, 0, 0);
      chk("R5 cut leaves one entry", enq_full == 1'b0, 32'(enq_full), 0);
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 1);
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 1);
      idle(1);
      chk("R10 stray confirm no effect", mem_req_valid == 1'b0, 32'(mem_req_valid), 0);
      cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
      chk("R10 later store confirmed once", mem_req_valid == 1'b1, 32'(mem_req_valid), 1);
      idle(1);

      // R6: flush keeps confirmed prefix
      repeat (3) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc(1, 0, 0, 1, 0, 0, 0, 1, 0);
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 1);
      idle(1);
      chk("R6 only confirmed survives", mem_req_valid == 1'b0, 32'(mem_req_valid), 0);

      // Sweeps with varied densities; R8 via ready gaps
      for (int ph = 0; ph < 8; ph++) begin
         for (int c = 0; c < 1500; c++) begin
            cyc($urandom_range(0, 3) < 2 + (ph & 1),
                $urandom_range(0, 1),
                TW'($urandom_range(0, 3)),
                $urandom_range(0, 3) < 1 + (ph >> 1),
                $urandom_range(0, 3) == 0,
                $urandom_range(0, 7) < (ph & 3),
                TW'($urandom_range(0, 3)),
                $urandom_range(0, 63) < ph,
                $urandom_range(0, 3) < 1 + (ph % 3));
         end
      end
      check_ports();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule